// File: doc/BRIEF.md
# Floating-Point Status Single-Bit Writer

This execution unit takes one decoded 32-bit instruction word at a time and changes a single bit of a 32-bit floating-point status and control register. Two operations are recognised: one forces the selected bit to 0 and the other forces it to 1. The bit is named by a 5-bit index that counts from the most significant end. Index 0 is the top bit, the overall exception flag. The two summary bits at indices 1 and 2 are derived state, so a request aimed at either of them leaves the register as it was.

When the instruction carries its record flag, the unit copies the four most significant status bits into field 1 of a 32-bit condition register. This copy is taken after the bit write. Any other word raises an unsupported flag and touches neither register.

A caller presents the word together with a one-cycle valid strobe. The result is visible on the next clock edge, and a one-cycle done pulse accompanies it. There is no handshake or serialisation.

Top module: `fp_status_bit_writer`

## Requirements
- R1: A synchronous active-high reset sets the status register and the condition register to zero and holds both done and unsupported low.
- R2: The word is read with bit 0 as its most significant bit. The primary opcode is in bits 0–5 (vector bits 31:26), the bit index in bits 6–10 (vector bits 25:21), the extended opcode in bits 21–30 (vector bits 10:1) and the record flag in bit 31 (vector bit 0). Bits 11–20 are ignored.
- R3: Primary opcode 63 with extended opcode 70 (word 0xFC00008C when every other field is zero) writes 0 to the selected bit. The other 31 bits are left unchanged.
- R4: Primary opcode 63 with extended opcode 38 writes 1 to the selected bit. The other 31 bits are left unchanged.
- R5: Index n selects register bit position 31−n, so index 0 is the MSB.
- R6: A supported request with index 1 or 2 leaves the status register unchanged and still produces done.
- R7: When the record flag is 1 on a supported word, the condition register takes the post-write status bits 31:28 in bits 27:24 (field 1). Its other 28 bits do not change.
- R8: When the record flag is 0, the condition register does not change.
- R9: A valid word that matches neither opcode pair leaves both registers unchanged. It pulses unsupported for one cycle and does not raise done.
- R10: Results and the done pulse appear on the clock edge that samples valid, and done lasts exactly one cycle. With valid low, neither register changes.

## Ports
| Port | Direction | Width | Description |
| --- | --- | --- | --- |
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| instrValid | input | 1 | Instruction word is present this cycle |
| instrWord | input | 32 | Decoded instruction word |
| statusReg | output | 32 | Floating-point status and control register |
| condReg | output | 32 | Condition register |
| done | output | 1 | One-cycle pulse for a supported instruction |
| unsupported | output | 1 | One-cycle pulse for an unrecognised word |

## Verification
The bench sweeps all 32 indices through both operations with the record flag on and off. It therefore catches a design that counts the index from the wrong end, which would change the mirrored bit position. It also catches one that lets the summary bits change, or one that copies the condition field from the status value before the write instead of after it. Neighbouring opcode values and other primary opcodes are sent to confirm that they change nothing and raise only the unsupported flag. Idle cycles after each burst confirm that done falls after one cycle and that neither register changes.

// File: rtl/fsbw_pkg.sv
package fsbw_pkg;
  localparam int DATA_W = 32;
  localparam int IDX_W  = 5;

  typedef struct packed {
    logic             bitWrite;
    logic             bitValue;
    logic [IDX_W-1:0] bitIdx;
    logic             crRecord;
  } ctrlStrobes_t;
endpackage

// File: rtl/fsbw_ctrl.sv
module fsbw_ctrl
  import fsbw_pkg::*;
#(
  parameter int unsigned OPC_PRIMARY   = 63,
  parameter int unsigned XO_CLEAR      = 70,
  parameter int unsigned XO_SET        = 38,
  parameter logic [DATA_W-1:0] PROT_IDX_MASK = 32'h0000_0006
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              instrValid,
  input  logic [DATA_W-1:0] instrWord,
  output ctrlStrobes_t      strobes,
  output logic              donePulse,
  output logic              unsupPulse
);
  localparam int OPC_W = 6;
  localparam int XO_W  = 10;
  localparam int OPC_LSB = DATA_W - OPC_W;
  localparam int IDX_LSB = OPC_LSB - IDX_W;

  logic [OPC_W-1:0] opField;
  logic [XO_W-1:0]  xoField;
  logic [IDX_W-1:0] idxField;
  logic             rcField;
  logic             isClear, isSet, isHit, isProtected;

  always_comb begin
    opField     = instrWord[DATA_W-1 -: OPC_W];
    idxField    = instrWord[IDX_LSB +: IDX_W];
    xoField     = instrWord[XO_W:1];
    rcField     = instrWord[0];
    isClear     = (opField == OPC_W'(OPC_PRIMARY)) && (xoField == XO_W'(XO_CLEAR));
    isSet       = (opField == OPC_W'(OPC_PRIMARY)) && (xoField == XO_W'(XO_SET));
    isHit       = isClear || isSet;
    isProtected = PROT_IDX_MASK[idxField];

    strobes.bitWrite = instrValid && isHit && !isProtected;
    strobes.bitValue = isSet;
    strobes.bitIdx   = idxField;
    strobes.crRecord = instrValid && isHit && rcField;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      donePulse  <= 1'b0;
      unsupPulse <= 1'b0;
    end else begin
      donePulse  <= instrValid && isHit;
      unsupPulse <= instrValid && !isHit;
    end
  end
endmodule

// File: rtl/fsbw_datapath.sv
module fsbw_datapath
  import fsbw_pkg::*;
#(
  parameter int CR_FIELD = 1
) (
  input  logic              clk,
  input  logic              rst,
  input  ctrlStrobes_t      strobes,
  output logic [DATA_W-1:0] statusReg,
  output logic [DATA_W-1:0] condReg
);
  localparam int FIELD_W = 4;
  localparam int CR_LSB  = DATA_W - FIELD_W * (CR_FIELD + 1);

  logic [DATA_W-1:0] selMask;
  logic [DATA_W-1:0] nextStatus;

  for (genvar g = 0; g < DATA_W; g++) begin : g_sel
    assign selMask[g] = (strobes.bitIdx == IDX_W'(DATA_W - 1 - g));
  end

  always_comb begin
    nextStatus = statusReg;
    if (strobes.bitWrite) begin
      if (strobes.bitValue) nextStatus = statusReg | selMask;
      else                  nextStatus = statusReg & ~selMask;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      statusReg <= '0;
      condReg   <= '0;
    end else begin
      statusReg <= nextStatus;
      if (strobes.crRecord)
        condReg[CR_LSB +: FIELD_W] <= nextStatus[DATA_W-1 -: FIELD_W];
    end
  end
endmodule

// File: rtl/fp_status_bit_writer.sv
module fp_status_bit_writer
  import fsbw_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              instrValid,
  input  logic [DATA_W-1:0] instrWord,
  output logic [DATA_W-1:0] statusReg,
  output logic [DATA_W-1:0] condReg,
  output logic              done,
  output logic              unsupported
);
  ctrlStrobes_t strobes;

  fsbw_ctrl i_ctrl (
    .clk        (clk),
    .rst        (rst),
    .instrValid (instrValid),
    .instrWord  (instrWord),
    .strobes    (strobes),
    .donePulse  (done),
    .unsupPulse (unsupported)
  );

  fsbw_datapath i_datapath (
    .clk       (clk),
    .rst       (rst),
    .strobes   (strobes),
    .statusReg (statusReg),
    .condReg   (condReg)
  );
endmodule

// File: rtl/fsbw_checker.sv
module fsbw_checker (
  input logic        clk,
  input logic        rst,
  input logic        instrValid,
  input logic [31:0] instrWord,
  input logic [31:0] statusReg,
  input logic [31:0] condReg,
  input logic        done,
  input logic        unsupported
);
  AST_RESET_ZERO: assert property (@(posedge clk)
    $past(rst) |-> (statusReg == 32'h0 && condReg == 32'h0 && !done && !unsupported)); // R1

  AST_SUMMARY_KEPT: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(instrValid) && ($past(instrWord[25:21]) == 5'd1 || $past(instrWord[25:21]) == 5'd2))
    |-> $stable(statusReg)); // R6

  AST_ONE_BIT: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> ($countones(statusReg ^ $past(statusReg)) <= 1)); // R3

  AST_CR_OTHERS: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> ((condReg & 32'hF0FF_FFFF) == ($past(condReg) & 32'hF0FF_FFFF))); // R7

  AST_NO_RECORD: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(instrWord[0])) |-> $stable(condReg)); // R8

  AST_FLAGS_EXCL: assert property (@(posedge clk) disable iff (rst)
    !(done && unsupported)); // R9

  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(instrValid)) |-> ($stable(statusReg) && $stable(condReg) && !done && !unsupported)); // R10
endmodule

bind fp_status_bit_writer fsbw_checker i_fsbw_checker (
  .clk         (clk),
  .rst         (rst),
  .instrValid  (instrValid),
  .instrWord   (instrWord),
  .statusReg   (statusReg),
  .condReg     (condReg),
  .done        (done),
  .unsupported (unsupported)
);

// File: tb/test_fp_status_bit_writer.sv
`timescale 1ns/1ps
module test_fp_status_bit_writer;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        instrValid = 1'b0;
  logic [31:0] instrWord = 32'h0;
  logic [31:0] statusReg, condReg;
  logic        done, unsupported;

  int checks = 0;
  int fails  = 0;
  logic [31:0] expStatus = 32'h0;
  logic [31:0] expCond   = 32'h0;

  always #2 clk = ~clk;

  fp_status_bit_writer i_fp_status_bit_writer (
    .clk(clk), .rst(rst), .instrValid(instrValid), .instrWord(instrWord),
    .statusReg(statusReg), .condReg(condReg), .done(done), .unsupported(unsupported)
  );

  function automatic logic [31:0] mkWord(int op, int idx, int xo, bit rc, logic [9:0] filler);
    return {op[5:0], idx[4:0], filler, xo[9:0], rc};
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%08h expected=%08h", req, act, exp);
    end
  endtask

  task automatic issue(logic [31:0] word, string req);
    int  op  = int'(word[31:26]);
    int  xo  = int'(word[10:1]);
    int  idx = int'(word[25:21]);
    bit  hit = (op == 63) && (xo == 70 || xo == 38);
    @(negedge clk);
    instrValid = 1'b1;
    instrWord  = word;
    if (hit) begin
      if (idx != 1 && idx != 2) begin
        if (xo == 38) expStatus = expStatus | (32'h1 << (31 - idx));
        else          expStatus = expStatus & ~(32'h1 << (31 - idx));
      end
      if (word[0]) expCond[27:24] = expStatus[31:28];
    end
    @(posedge clk);
    #1;
    check(req, statusReg, expStatus);
    check(word[0] ? "R7" : "R8", condReg, expCond);
    check(hit ? "R10 done" : "R9 unsupported", {30'h0, done, unsupported}, hit ? 32'h2 : 32'h1);
  endtask

  task automatic idle(string req);
    @(negedge clk);
    instrValid = 1'b0;
    instrWord  = 32'hFFFF_FFFF;
    @(posedge clk);
    #1;
    check(req, statusReg, expStatus);
    check(req, condReg, expCond);
    check(req, {30'h0, done, unsupported}, 32'h0);
  endtask

  initial begin
    #(200000 * 4);
    fails++;
    $display("FAIL watchdog actual=%0d expected=%0d", checks, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    check("R1 status", statusReg, 32'h0);
    check("R1 cond", condReg, 32'h0);
    check("R1 flags", {30'h0, done, unsupported}, 32'h0);
    @(negedge clk);
    rst = 1'b0;

    // R4, R5, R6: set every index, record flag on odd indices
    for (int i = 0; i < 32; i++)
      issue(mkWord(63, i, 38, i[0], 10'h000), "R4 set");
    idle("R10 idle");
    check("R5 mapping", statusReg, 32'h9FFF_FFFF);

    // R3, R2: clear every index, filler in ignored bits, record on even indices
    for (int i = 0; i < 32; i++)
      issue(mkWord(63, i, 70, !i[0], 10'(i * 37)), "R3 clear");
    idle("R10 idle");

    // R5: single bits in isolation, walking from the top
    for (int i = 0; i < 32; i += 5) begin
      issue(mkWord(63, i, 38, 1'b1, 10'h3FF), "R5 set");
      issue(mkWord(63, i, 70, 1'b1, 10'h155), "R5 clear");
    end
    issue(32'hFC00008C, "R3 plain word");

    // R6: summary indices with record flag
    issue(mkWord(63, 0, 38, 1'b0, 10'h0), "R4 set top");
    issue(mkWord(63, 1, 38, 1'b1, 10'h0), "R6 summary1");
    issue(mkWord(63, 2, 38, 1'b1, 10'h0), "R6 summary2");
    issue(mkWord(63, 3, 38, 1'b1, 10'h0), "R4 set idx3");
    check("R7 field", condReg, 32'h0900_0000);

    // R9: near-miss and foreign opcodes
    issue(mkWord(63, 4, 71, 1'b1, 10'h0), "R9 xo71");
    issue(mkWord(63, 4, 134, 1'b1, 10'h0), "R9 xo134");
    issue(mkWord(31, 4, 70, 1'b1, 10'h0), "R9 op31");
    issue(mkWord(62, 4, 38, 1'b1, 10'h0), "R9 op62");
    issue(32'h0000_0000, "R9 zero");
    idle("R10 idle");
    idle("R10 idle2");

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule